// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table in memory. A requester gives it a virtual address, the byte address of the top-level table and a flag saying whether the access is a read or a write. The walker then reads one or two table entries over a plain request/valid memory port. It either returns the physical address or stops with a fault code that tells system software what is missing.

Virtual address bits [31:24] select an entry in the top-level table. Bits [23:12] select an entry in the second-level table that the first entry points to. Bits [11:0] are the offset inside a 4 KB page. Every entry is a 32-bit word with this layout:

- bit 0: present
- bit 1: read allowed
- bit 2: write allowed
- bits [31:12]: frame number

Bits [11:3] are ignored. The read and write bits only matter in second-level entries. A result stays on the response port until the requester acknowledges it. The walker takes one request at a time.

Top module: `pt_walker`

## Requirements
- R1: After a request is accepted, the first memory read targets `req_base + 4*vaddr[31:24]`.
- R2: If bit 0 of the first-level entry is 0, the walk ends with fault code 1 (table missing) and no second read is issued.
- R3: If the first-level entry is present, the second read targets `{entry[31:12], 12'h000} + 4*vaddr[23:12]`.
- R4: If bit 0 of the second-level entry is 0, the walk ends with fault code 2 (page missing), whatever its permission bits are.
- R5: If the second-level entry is present, a read with bit 1 clear ends with fault code 3 (protection). A write with bit 2 clear also ends with fault code 3.
- R6: A walk with no fault returns fault code 0 and physical address `{entry[31:12], vaddr[11:0]}`. A walk that faults returns physical address 0.
- R7: `mem_req` stays high with a stable `mem_addr` until `mem_valid` is seen. The walker uses `mem_rdata` only in a cycle where `mem_valid` is high, so a memory may take any number of cycles to answer.
- R8: A request is accepted only when `req_ready` is high, which happens only while the walker is idle. A request offered during a walk or while a response is pending has no effect on that walk's result.
- R9: `rsp_valid`, `rsp_paddr` and `rsp_fault` hold steady until `rsp_ack`. On the cycle after the acknowledge, `rsp_valid` is low and `req_ready` is high.
- R10: During and right after reset, `req_ready` is high and both `mem_req` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, a request is taken this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_base | input | 32 | Byte address of the top-level table |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_req | output | 1 | Table-entry read requested |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_valid | input | 1 | Read data is valid this cycle |
| mem_rdata | input | 32 | Entry word returned by memory |
| rsp_valid | output | 1 | Result available |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 table missing, 2 page missing, 3 protection |
| rsp_ack | input | 1 | Result consumed |

## Verification
A wrong state register would show up at the memory port first. A missing or extra read, or a wrong `mem_addr`, appears on the next cycle, before any response is formed. A corrupted latched address or table base gives the wrong entry, and so the wrong fault code or frame, as soon as the walk finishes. The sweep covers every top-level index, with boundary second-level indices, both access types and memory latencies from zero to three cycles. A late or lost acknowledge handshake appears as `rsp_valid` or `req_ready` being wrong one cycle after `rsp_ack`.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_L1   = 2'd1,
    ST_L2   = 2'd2,
    ST_DONE = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_TABLE = 2'd1,
    FLT_PAGE  = 2'd2,
    FLT_PROT  = 2'd3
  } fault_e;

  localparam int PRESENT_BIT = 0;
  localparam int READ_BIT    = 1;
  localparam int WRITE_BIT   = 2;
endpackage

// File: rtl/pte_decode.sv
module pte_decode
  import pt_walker_pkg::*;
#(
  parameter int PTE_W = 32,
  parameter int OFF_W = 12,
  localparam int FRAME_W = PTE_W - OFF_W
) (
  input  logic [PTE_W-1:0]   pte,
  input  logic               is_write,
  output logic               present,
  output logic               allowed,
  output logic [FRAME_W-1:0] frame
);
  // Field extraction for one table entry; permission picked by access type.
  assign present = pte[PRESENT_BIT];
  assign allowed = is_write ? pte[WRITE_BIT] : pte[READ_BIT];
  assign frame   = pte[PTE_W-1:OFF_W];
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_valid,
  input  logic        present,
  input  logic        allowed,
  input  logic        rsp_ack,
  output walk_state_e state,
  output logic        take_req,
  output logic        take_l1,
  output logic        take_result,
  output fault_e      result_fault
);
  walk_state_e state_d;

  always_comb begin
    state_d      = state;
    take_req     = 1'b0;
    take_l1      = 1'b0;
    take_result  = 1'b0;
    result_fault = FLT_NONE;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          take_req = 1'b1;
          state_d  = ST_L1;
        end
      end
      ST_L1: begin
        if (mem_valid) begin
          if (!present) begin
            take_result  = 1'b1;
            result_fault = FLT_TABLE;
            state_d      = ST_DONE;
          end else begin
            take_l1 = 1'b1;
            state_d = ST_L2;
          end
        end
      end
      ST_L2: begin
        if (mem_valid) begin
          take_result = 1'b1;
          if (!present)      result_fault = FLT_PAGE;
          else if (!allowed) result_fault = FLT_PROT;
          else               result_fault = FLT_NONE;
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        if (rsp_ack) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  // R7: a table read keeps waiting until memory answers
  p_wait_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_L1 && !mem_valid) |=> (state == ST_L1));

  // R9: a finished walk stays finished until acknowledged
  p_hold_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && !rsp_ack) |=> (state == ST_DONE));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTE_W  = 32,
  parameter int L1_W   = 8,
  parameter int L2_W   = 12,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [ADDR_W-1:0] req_base,
  input  logic              req_write,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [PTE_W-1:0]  mem_rdata,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_fault,
  input  logic              rsp_ack
);
  localparam int FRAME_W     = PTE_W - OFF_W;
  localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);

  walk_state_e       state;
  logic              take_req, take_l1, take_result;
  fault_e            result_fault;
  logic              pte_present, pte_allowed;
  logic [FRAME_W-1:0] pte_frame;

  logic [ADDR_W-1:0] va_q, base_q, l2base_q, paddr_q;
  logic              wr_q;
  fault_e            fault_q;

  logic [L1_W-1:0]   idx1;
  logic [L2_W-1:0]   idx2;
  logic [ADDR_W-1:0] l1_addr, l2_addr, paddr_d, l2base_d;

  walk_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .mem_valid    (mem_valid),
    .present      (pte_present),
    .allowed      (pte_allowed),
    .rsp_ack      (rsp_ack),
    .state        (state),
    .take_req     (take_req),
    .take_l1      (take_l1),
    .take_result  (take_result),
    .result_fault (result_fault)
  );

  pte_decode #(.PTE_W(PTE_W), .OFF_W(OFF_W)) u_dec (
    .pte      (mem_rdata),
    .is_write (wr_q),
    .present  (pte_present),
    .allowed  (pte_allowed),
    .frame    (pte_frame)
  );

  // Index extraction and entry address formation
  always_comb begin
    idx1     = va_q[ADDR_W-1 -: L1_W];
    idx2     = va_q[OFF_W +: L2_W];
    l1_addr  = base_q + (ADDR_W'(idx1) << ENTRY_SHIFT);
    l2_addr  = l2base_q + (ADDR_W'(idx2) << ENTRY_SHIFT);
    l2base_d = ADDR_W'({pte_frame, {OFF_W{1'b0}}});
    paddr_d  = (result_fault == FLT_NONE) ?
               ADDR_W'({pte_frame, va_q[OFF_W-1:0]}) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q     <= '0;
      base_q   <= '0;
      wr_q     <= 1'b0;
      l2base_q <= '0;
      paddr_q  <= '0;
      fault_q  <= FLT_NONE;
    end else begin
      if (take_req) begin
        va_q   <= req_vaddr;
        base_q <= req_base;
        wr_q   <= req_write;
      end
      if (take_l1) l2base_q <= l2base_d;
      if (take_result) begin
        paddr_q <= paddr_d;
        fault_q <= result_fault;
      end
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign mem_req   = (state == ST_L1) || (state == ST_L2);
  assign mem_addr  = (state == ST_L2) ? l2_addr : l1_addr;
  assign rsp_valid = (state == ST_DONE);
  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;

  // R2: an absent first-level entry finishes the walk with the table fault
  p_l1_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_L1 && mem_valid && !mem_rdata[PRESENT_BIT])
      |=> (rsp_valid && rsp_fault == 2'd1 && !mem_req));

  // R6: a successful translation keeps the page offset
  p_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd0) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

  // R7: address stays put while memory has not answered
  p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R8: the walker is never ready while busy
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !rsp_valid));

  // R9: response held until acknowledged, then ready again
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ack) |=> (req_ready && !rsp_valid));
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  localparam logic [31:0] BASE    = 32'h0004_0000;
  localparam logic [31:0] L2_AREA = 32'h0010_0000;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_vaddr, req_base;
  logic        mem_req, mem_valid;
  logic [31:0] mem_addr, mem_rdata;
  logic        rsp_valid, rsp_ack;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int n_chk = 0;
  int n_fail = 0;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_base(req_base), .req_write(req_write),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_ack(rsp_ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Table contents, computed arithmetically
  function automatic logic [31:0] l1_entry(input int i);
    logic [19:0] fr;
    fr = 20'(32'h100 + 4 * i);
    return {fr, 12'h0} | 32'((i % 4) != 3);
  endfunction

  function automatic logic [31:0] l2_entry(input int i, input int j);
    logic [19:0] fr;
    logic p, r, w;
    fr = 20'((i * 131 + j * 17) ^ 32'h5a5a5);
    p  = ((i + j) % 5) != 4;
    r  = ((i + j) % 3) != 0;
    w  = ((i * 7 + j) % 4) < 2;
    return {fr, 12'(j & 9'h1ff) << 3} | {29'd0, w, r, p};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] k;
    if (a >= BASE && a < BASE + 32'd1024) return l1_entry(int'((a - BASE) >> 2));
    if (a >= L2_AREA) begin
      k = a - L2_AREA;
      return l2_entry(int'(k >> 14), int'((k >> 2) & 32'hfff));
    end
    return 32'h0;
  endfunction

  task automatic serve(input logic [31:0] exp_addr, input int lat, input string req);
    for (int c = 0; c < lat; c++) begin
      chk(mem_req === 1'b1 && mem_addr === exp_addr, "R7 wait", mem_addr, exp_addr);
      mem_valid = 1'b0;
      mem_rdata = 32'hdead_beef;
      @(negedge clk);
    end
    chk(mem_req === 1'b1 && mem_addr === exp_addr, req, mem_addr, exp_addr);
    mem_valid = 1'b1;
    mem_rdata = mem_word(mem_addr);
    @(negedge clk);
    mem_valid = 1'b0;
    mem_rdata = 32'hdead_beef;
  endtask

  task automatic walk(input logic [31:0] va, input logic wr, input int lat);
    int i, j;
    logic [31:0] e1, e2, exp_pa;
    logic [1:0]  exp_f;
    string tag;
    i = int'(va[31:24]);
    j = int'(va[23:12]);
    e1 = l1_entry(i);
    e2 = l2_entry(i, j);
    if (!e1[0])                begin exp_f = 2'd1; tag = "R2"; end
    else if (!e2[0])           begin exp_f = 2'd2; tag = "R4"; end
    else if (!(wr ? e2[2] : e2[1])) begin exp_f = 2'd3; tag = "R5"; end
    else                       begin exp_f = 2'd0; tag = "R6"; end
    exp_pa = (exp_f == 2'd0) ? {e2[31:12], va[11:0]} : 32'h0;

    req_valid = 1'b1; req_vaddr = va; req_base = BASE; req_write = wr;
    @(negedge clk);
    // R8: busy walker ignores a conflicting request
    req_vaddr = ~va; req_write = ~wr; req_base = 32'h0;
    chk(req_ready === 1'b0, "R8 busy", {31'd0, req_ready}, 32'd0);
    serve(BASE + {22'd0, va[31:24], 2'b00}, lat, "R1 l1 addr");
    if (e1[0]) serve({e1[31:12], 12'h0} + {18'd0, va[23:12], 2'b00}, lat, "R3 l2 addr");
    chk(rsp_valid === 1'b1 && mem_req === 1'b0, {tag, " done"}, {30'd0, rsp_valid, mem_req}, 32'd2);
    chk(rsp_fault === exp_f, {tag, " fault"}, {30'd0, rsp_fault}, {30'd0, exp_f});
    chk(rsp_paddr === exp_pa, {tag, " paddr"}, rsp_paddr, exp_pa);
    @(negedge clk);
    chk(rsp_valid === 1'b1 && rsp_fault === exp_f && rsp_paddr === exp_pa,
        "R9 hold", rsp_paddr, exp_pa);
    req_valid = 1'b0;
    rsp_ack = 1'b1;
    @(negedge clk);
    rsp_ack = 1'b0;
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R9 release",
        {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_base = '0; req_write = 1'b0;
    mem_valid = 1'b0; mem_rdata = '0; rsp_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && mem_req === 1'b0 && rsp_valid === 1'b0, "R10 in reset",
        {29'd0, req_ready, mem_req, rsp_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && mem_req === 1'b0 && rsp_valid === 1'b0, "R10 after reset",
        {29'd0, req_ready, mem_req, rsp_valid}, 32'd4);

    for (int i = 0; i < 256; i++) begin
      for (int s = 0; s < 4; s++) begin
        logic [11:0] j, off;
        case (s)
          0: j = 12'h000;
          1: j = 12'hfff;
          default: j = 12'((i * 37 + s * 1013) & 12'hfff);
        endcase
        off = 12'((i * 91 + s * 7) & 12'hfff);
        walk({8'(i), j, off}, s[0], (i + s) % 4);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule